// File: doc/BRIEF.md
# Bus Remote Wake-up Detector

This block watches the digitised level of several single-wire vehicle buses and recognises a remote wake-up on each one on its own. A wake-up is a dominant period that lasts at least a minimum time and then ends with a return to recessive. The detector does not signal when the minimum time runs out. It waits for the recessive edge, then waits a further short delay, and only then pulses a one-cycle wake strobe for the mode controller. In the same cycle it sets a per-channel wake flag. The mode controller uses that flag to pull the channel's receive line low while the device sits in standby, so it shows which bus caused the wake.

The analog comparators that turn bus voltage into a level sit outside this block. Each bus input is 1 for dominant and 0 for recessive, and it passes through a two-flop synchroniser before any counting. The mode controller raises a detection enable during sleep and during the normal-to-sleep filter window. It pulses a normal-entry input when the device enters normal mode, and that pulse clears the flags. Power loss appears as reset. Both time windows are parameters counted in clock cycles.

Top module: `wake_detect_array`

## Requirements
- R1: With detection enabled, if `bus_dom_i[c]` is 1 for at least WAKE_CYC consecutive rising edges and then returns to 0, `wake_strobe_o[c]` is 1 for exactly one cycle, starting after the (EDGE_DLY_CYC+3)-th rising edge counted from the return to 0.
- R2: `wake_flag_o[c]` becomes 1 in the same cycle as the strobe on channel c, and stays 1 after the strobe ends.
- R3: A dominant period shorter than WAKE_CYC edges produces no strobe and no flag, and a recessive gap clears the count, so several short pulses in a row never add up to a wake.
- R4: A bus held dominant produces no strobe for as long as it stays dominant. The wake is reported only after it is released.
- R5: Channels are independent. A wake on one channel strobes and flags only that channel.
- R6: While `det_en_i` is 0, dominant time is not counted, and any partial or complete count that has not yet seen its recessive edge is discarded.
- R7: Once the recessive edge of a valid wake has been seen, the strobe is delivered on schedule even if `det_en_i` falls or the bus turns dominant again during the delay.
- R8: A 1 on `normal_entry_i` at a rising edge clears every wake flag, drops any pending wake, and resets all counts.
- R9: If `normal_entry_i` is 1 at the same edge where a strobe would otherwise be issued, no strobe appears and the flag stays 0.
- R10: After reset, all strobes and flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, also used for power loss |
| det_en_i | input | 1 | Detection enable from the mode controller |
| normal_entry_i | input | 1 | One-cycle pulse on entry to normal mode |
| bus_dom_i | input | NCH | Per-channel bus level, 1 = dominant, asynchronous |
| wake_strobe_o | output | NCH | One-cycle wake pulse per channel |
| wake_flag_o | output | NCH | Latched wake indication per channel |

## Verification
The collision that matters happens when the post-edge delay of a wake ends and the mode controller's normal-entry pulse arrives at the same clock edge. The strobe would set the flag while the entry pulse clears it. The bench releases a valid dominant pulse and counts edges from the release. It places the entry pulse exactly on the edge where the strobe is due. The bench then requires that no strobe appears in that cycle or later and that the flag stays clear. A separate case pulses normal entry after a completed wake, which shows that the clear works on its own.

// File: rtl/wake_pkg.sv
package wake_pkg;
    typedef enum logic [1:0] {
        WK_HUNT  = 2'd0,
        WK_ARMED = 2'd1,
        WK_DELAY = 2'd2
    } wake_state_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = async_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.s2;
endmodule

// File: rtl/wake_channel.sv
module wake_channel
    import wake_pkg::*;
#(
    parameter int WAKE_CYC     = 90,
    parameter int EDGE_DLY_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_en_i,
    input  logic normal_entry_i,
    input  logic dom_i,
    output logic strobe_o,
    output logic flag_o
);
    localparam int CW = $clog2(WAKE_CYC + 1);
    localparam int DW = $clog2(EDGE_DLY_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(WAKE_CYC - 1);
    localparam logic [DW-1:0] DLY_LAST = DW'(EDGE_DLY_CYC - 1);

    typedef struct packed {
        wake_state_e   st;
        logic [CW-1:0] dom_cnt;
        logic [DW-1:0] dly_cnt;
        logic          strobe;
        logic          flag;
    } ch_t;

    ch_t ch_d, ch_q;

    always_comb begin
        ch_d        = ch_q;
        ch_d.strobe = 1'b0;
        if (normal_entry_i) begin
            ch_d.st      = WK_HUNT;
            ch_d.dom_cnt = '0;
            ch_d.dly_cnt = '0;
            ch_d.flag    = 1'b0;
        end else begin
            unique case (ch_q.st)
                WK_HUNT: begin
                    if (!det_en_i || !dom_i) begin
                        ch_d.dom_cnt = '0;
                    end else if (ch_q.dom_cnt == CNT_LAST) begin
                        ch_d.dom_cnt = '0;
                        ch_d.st      = WK_ARMED;
                    end else begin
                        ch_d.dom_cnt = ch_q.dom_cnt + 1'b1;
                    end
                end
                WK_ARMED: begin
                    if (!det_en_i) begin
                        ch_d.st = WK_HUNT;
                    end else if (!dom_i) begin
                        ch_d.st      = WK_DELAY;
                        ch_d.dly_cnt = '0;
                    end
                end
                WK_DELAY: begin
                    if (ch_q.dly_cnt == DLY_LAST) begin
                        ch_d.strobe  = 1'b1;
                        ch_d.flag    = 1'b1;
                        ch_d.st      = WK_HUNT;
                        ch_d.dly_cnt = '0;
                    end else begin
                        ch_d.dly_cnt = ch_q.dly_cnt + 1'b1;
                    end
                end
                default: begin
                    ch_d.st = WK_HUNT;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q.st      <= WK_HUNT;
            ch_q.dom_cnt <= '0;
            ch_q.dly_cnt <= '0;
            ch_q.strobe  <= 1'b0;
            ch_q.flag    <= 1'b0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign strobe_o = ch_q.strobe;
    assign flag_o   = ch_q.flag;
endmodule

// File: rtl/wake_detect_array.sv
module wake_detect_array #(
    parameter int NCH          = 4,
    parameter int WAKE_CYC     = 90,
    parameter int EDGE_DLY_CYC = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           det_en_i,
    input  logic           normal_entry_i,
    input  logic [NCH-1:0] bus_dom_i,
    output logic [NCH-1:0] wake_strobe_o,
    output logic [NCH-1:0] wake_flag_o
);
    logic [NCH-1:0] dom_sync;

    wake_sync #(.W(NCH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (bus_dom_i),
        .sync_o  (dom_sync)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        wake_channel #(
            .WAKE_CYC     (WAKE_CYC),
            .EDGE_DLY_CYC (EDGE_DLY_CYC)
        ) u_ch (
            .clk            (clk),
            .rst_n          (rst_n),
            .det_en_i       (det_en_i),
            .normal_entry_i (normal_entry_i),
            .dom_i          (dom_sync[c]),
            .strobe_o       (wake_strobe_o[c]),
            .flag_o         (wake_flag_o[c])
        );
    end
endmodule

// File: rtl/wake_detect_chk.sv
module wake_detect_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           normal_entry_i,
    input logic [NCH-1:0] wake_strobe_o,
    input logic [NCH-1:0] wake_flag_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R1: the strobe lasts a single cycle
        assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
            wake_strobe_o[c] |=> !wake_strobe_o[c]);
        // R2: the flag is up whenever a strobe is issued
        assert_flag_with_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
            wake_strobe_o[c] |-> wake_flag_o[c]);
        // R2: the flag only rises together with a strobe
        assert_flag_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(wake_flag_o[c]) |-> wake_strobe_o[c]);
        // R8: the flag only falls after a normal-entry pulse
        assert_flag_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(wake_flag_o[c]) |-> $past(normal_entry_i));
        // R9: normal entry leaves no strobe and no flag behind
        assert_entry_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            normal_entry_i |=> (!wake_strobe_o[c] && !wake_flag_o[c]));
    end
endmodule

bind wake_detect_array wake_detect_chk #(.NCH(NCH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .normal_entry_i (normal_entry_i),
    .wake_strobe_o  (wake_strobe_o),
    .wake_flag_o    (wake_flag_o)
);

// File: tb/sim_wake_detect_array.sv
module sim_wake_detect_array;
    localparam int  NCH   = 4;
    localparam int  WAKE  = 12;
    localparam int  DLY   = 3;
    localparam time TCLK  = 10ns;
    localparam int  EXP_AT = DLY + 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           det_en = 1'b0;
    logic           nentry = 1'b0;
    logic [NCH-1:0] bus = '0;
    logic [NCH-1:0] strobe, flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    wake_detect_array #(.NCH(NCH), .WAKE_CYC(WAKE), .EDGE_DLY_CYC(DLY)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .det_en_i       (det_en),
        .normal_entry_i (nentry),
        .bus_dom_i      (bus),
        .wake_strobe_o  (strobe),
        .wake_flag_o    (flag)
    );

    always #(TCLK/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold_dom(input logic [NCH-1:0] m, input int n);
        bus = bus | m;
        repeat (n) @(negedge clk);
        bus = bus & ~m;
    endtask

    // Watch for a strobe on channel ch for up to lim cycles; report first cycle and stray strobes
    task automatic watch(input int ch, input int lim, output int at, output int stray);
        at = 0;
        stray = 0;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (strobe[ch] && at == 0) at = i;
            for (int k = 0; k < NCH; k++)
                if (k != ch && strobe[k]) stray++;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; det_en = 1'b0; nentry = 1'b0; bus = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_flags();
        nentry = 1'b1;
        @(negedge clk);
        nentry = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R10 strobe after reset", int'(strobe), 0);
        check("R10 flag after reset", int'(flag), 0);
    endtask

    task automatic t_exact_wake();
        int at, stray;
        det_en = 1'b1;
        hold_dom(4'b0001, WAKE);
        watch(0, EXP_AT + 6, at, stray);
        check("R1 strobe cycle after release", at, EXP_AT);
        check("R5 no strobe on other channels", stray, 0);
        check("R2 flag held after strobe", int'(flag), 1);
        check("R1 strobe single cycle", int'(strobe), 0);
        clear_flags();
    endtask

    task automatic t_short();
        int at, stray;
        det_en = 1'b1;
        hold_dom(4'b0010, WAKE - 1);
        watch(1, EXP_AT + 6, at, stray);
        check("R3 short pulse no strobe", at, 0);
        for (int p = 0; p < 3; p++) begin
            hold_dom(4'b0010, WAKE - 2);
            @(negedge clk);
        end
        watch(1, EXP_AT + 6, at, stray);
        check("R3 chained short pulses no strobe", at, 0);
        check("R3 flag stays clear", int'(flag), 0);
    endtask

    task automatic t_stuck();
        int at, stray;
        det_en = 1'b1;
        bus[2] = 1'b1;
        watch(2, 5 * WAKE, at, stray);
        check("R4 stuck dominant no strobe", at, 0);
        check("R4 stuck dominant no flag", int'(flag[2]), 0);
        bus[2] = 1'b0;
        watch(2, EXP_AT + 6, at, stray);
        check("R4 release after stuck wakes", at, EXP_AT);
        check("R5 only channel 2 flagged", int'(flag), 4);
        clear_flags();
    endtask

    task automatic t_two_channels();
        int at0, at3, s;
        det_en = 1'b1;
        bus = 4'b1001;
        repeat (WAKE) @(negedge clk);
        bus[3] = 1'b0;
        repeat (2) @(negedge clk);
        bus[0] = 1'b0;
        watch(3, EXP_AT - 2, at3, s);
        check("R5 channel 3 strobe timing", at3, EXP_AT - 2);
        watch(0, 6, at0, s);
        check("R5 channel 0 strobe timing", at0, 2);
        check("R5 two channels flagged", int'(flag), 9);
        clear_flags();
    endtask

    task automatic t_disable();
        int at, stray;
        det_en = 1'b1;
        bus[0] = 1'b1;
        repeat (WAKE - 2) @(negedge clk);
        det_en = 1'b0;
        repeat (2) @(negedge clk);
        det_en = 1'b1;
        repeat (WAKE - 4) @(negedge clk);
        bus[0] = 1'b0;
        watch(0, EXP_AT + 6, at, stray);
        check("R6 count discarded by disable", at, 0);
        bus[0] = 1'b1;
        repeat (WAKE + 2) @(negedge clk);
        det_en = 1'b0;
        @(negedge clk);
        bus[0] = 1'b0;
        @(negedge clk);
        det_en = 1'b1;
        watch(0, EXP_AT + 6, at, stray);
        check("R6 armed count discarded by disable", at, 0);
        check("R6 flag stays clear", int'(flag), 0);
    endtask

    task automatic t_pending();
        int at, stray;
        det_en = 1'b1;
        hold_dom(4'b0010, WAKE);
        repeat (3) @(negedge clk);
        det_en = 1'b0;
        bus[1] = 1'b1;
        watch(1, EXP_AT + 3, at, stray);
        check("R7 pending wake survives disable and bus", at, EXP_AT - 3);
        check("R7 flag set", int'(flag[1]), 1);
        bus[1] = 1'b0;
        repeat (3) @(negedge clk);
        nentry = 1'b1;
        @(negedge clk);
        nentry = 1'b0;
        check("R8 normal entry clears flag", int'(flag), 0);
    endtask

    task automatic t_collision();
        int at, stray;
        det_en = 1'b1;
        hold_dom(4'b0100, WAKE);
        repeat (EXP_AT - 1) @(negedge clk);
        nentry = 1'b1;
        @(negedge clk);
        nentry = 1'b0;
        check("R9 no strobe on collision edge", int'(strobe[2]), 0);
        check("R9 flag clear on collision", int'(flag[2]), 0);
        watch(2, 8, at, stray);
        check("R9 no late strobe", at, 0);
    endtask

    initial begin
        t_reset();
        t_exact_wake();
        t_short();
        t_stuck();
        t_two_channels();
        t_disable();
        t_pending();
        t_collision();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule